// File: doc/BRIEF.md
# Dual-Mode Subroutine Call Stack Controller

This block runs the subroutine call and return sequences for a small 4-bit processor core. A 4-bit mode register sits in the peripheral address space. Its top bit picks one of two compatibility modes. Its low bits pick which of two data-memory banks holds the stack. When the core asks for a call, the block writes the return address to the stack in the selected bank, one location per cycle, and then hands the new program counter back to the core. When the core asks for a return, the block reads the frame back in reverse order and hands back the saved address.

The legacy mode uses a two-location frame. The extended mode adds a third location that records the mode register as it stood when the call was made. A full call carries a 14-bit target. A fast call carries an 11-bit target that is zero-extended. Each kind of call costs a fixed number of cycles that depends on the mode. The memory port is one byte-wide location per access. Its 9-bit address is the bank bit followed by the 8-bit stack pointer. Read data is expected in the same cycle as the address.

Top module: `callstack_ctl`

## Requirements
- R1: After reset the mode register reads legacy mode (`legacyMode`=1) with bank 0 selected (`stackBank`=0), `spOut` is 0, and `busy`, `pcLoad` and `wrErr` are low.
- R2: A write with `regAddr`=12'hF84 and valid data loads the register. Bit 3 is the mode (1 = legacy, 0 = extended) and bit 0 is the stack bank. The new value shows on `legacyMode`/`stackBank` in the cycle after the write. Writes to any other address change nothing.
- R3: A write to 12'hF84 with bit 2 set or bit 1 set is discarded, leaving the register unchanged. `wrErr` is then high for exactly the one cycle after that write.
- R4: A full call (`callFast`=0) keeps `busy` high for 3 cycles after acceptance in legacy mode and 4 in extended mode. `pcLoad` is high only in the last of these cycles, with `pcOut` equal to `callTarget`.
- R5: A fast call (`callFast`=1) keeps `busy` high for 2 cycles in legacy mode and 3 in extended mode. `pcLoad` is high in the last cycle, with `pcOut` = {3'b000, `callTarget[10:0]`}.
- R6: Each push first decrements the stack pointer and then writes at {bank, new SP}. A frame is pushed in this order:
  - `retAddr[7:0]`
  - {2'b00, `retAddr[13:8]`}
  - in extended mode only, {4'h0, mode register}.
- R7: A return reads at {bank, SP} and then increments SP, one location per cycle. The frame size comes from the mode in effect when the return is accepted (2 cycles legacy, 3 extended). `pcLoad` is high in the last read cycle, with `pcOut` rebuilt as {high location[5:0], low location}.
- R8: Mode and bank are captured when a request is accepted. A register write in that same cycle, or later during the sequence, affects only later requests.
- R9: Requests that arrive while `busy` is high are ignored. When `callReq` and `retReq` are both high in an idle cycle, the call is taken and the return is dropped.
- R10: The 8-bit stack pointer wraps modulo 256 on both push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Peripheral register write strobe |
| regAddr | input | 12 | Peripheral write address |
| regWrData | input | 4 | Peripheral write data |
| callReq | input | 1 | Call request (sampled when idle) |
| callFast | input | 1 | 1 = fast call with 11-bit target |
| callTarget | input | 14 | Call destination |
| retAddr | input | 14 | Return address to save |
| retReq | input | 1 | Return request (sampled when idle) |
| busy | output | 1 | Sequence in progress |
| pcLoad | output | 1 | Program counter load strobe |
| pcOut | output | 14 | New program counter, valid with pcLoad |
| wrErr | output | 1 | Rejected register write, one-cycle pulse |
| legacyMode | output | 1 | Current mode bit |
| stackBank | output | 1 | Current stack bank |
| spOut | output | 8 | Stack pointer |
| memWe | output | 1 | Stack memory write enable |
| memRe | output | 1 | Stack memory read enable |
| memAddr | output | 9 | Stack memory address {bank, pointer} |
| memWdata | output | 8 | Stack memory write data |
| memRdata | input | 8 | Stack memory read data, same cycle |

## Verification
A register write can land in the same cycle that a call is accepted. The bench provokes this by raising `regWrEn` with a mode change on the exact edge that accepts `callReq`. The expected result is that the frame length, bank and latency all follow the old register value, and that the new value shows right after. A second collision is `callReq` and `retReq` together in the idle cycle, followed by both again during `busy`. There the scoreboard must see exactly one call frame and no read sequence.

// File: rtl/callstk_pkg.sv
package callstk_pkg;
  localparam int PC_W   = 14;
  localparam int LOC_W  = 8;
  localparam int SP_W   = 8;
  localparam int FAST_W = 11;
  localparam int REG_W  = 4;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] SBS_ADDR = 12'hF84;

  localparam int HI_W      = PC_W - LOC_W;
  localparam int LEG_FRAME = (PC_W + LOC_W - 1) / LOC_W;
  localparam int EXT_FRAME = LEG_FRAME + 1;
  localparam int CNT_W     = $clog2(EXT_FRAME + 2);
  localparam int MADDR_W   = SP_W + 1;

  typedef enum logic [1:0] {
    ITEM_LOW,
    ITEM_HIGH,
    ITEM_EXTRA
  } item_e;

  typedef struct packed {
    logic  snap;
    logic  push;
    logic  pop;
    logic  ldCall;
    logic  ldRet;
    logic  holdHigh;
    item_e item;
  } strobe_t;
endpackage

// File: rtl/callstk_ctrl.sv
module callstk_ctrl
  import callstk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    callReq,
  input  logic    callFast,
  input  logic    retReq,
  input  logic    legacyMode,
  output strobe_t stb,
  output logic    busy,
  output logic    pcLoad
);
  typedef enum logic [1:0] {ST_IDLE, ST_CALL, ST_RET} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             snapLegacy;
  logic             snapFast;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] callLen;
  logic [CNT_W-1:0] popIdx;
  logic             lastStep;

  function automatic item_e idxItem(input logic [CNT_W-1:0] idx);
    if (idx == CNT_W'(0))      return ITEM_LOW;
    else if (idx == CNT_W'(1)) return ITEM_HIGH;
    else                       return ITEM_EXTRA;
  endfunction

  always_comb begin
    frameLen = snapLegacy ? CNT_W'(LEG_FRAME) : CNT_W'(EXT_FRAME);
    callLen  = frameLen + (snapFast ? CNT_W'(0) : CNT_W'(1));
    popIdx   = frameLen - CNT_W'(1) - cnt;
    stb      = '0;
    stb.snap = (state == ST_IDLE) && (callReq || retReq);
    lastStep = 1'b0;
    case (state)
      ST_CALL: begin
        stb.push   = (cnt < frameLen);
        stb.item   = idxItem(cnt);
        stb.ldCall = (cnt == callLen - CNT_W'(1));
        lastStep   = stb.ldCall;
      end
      ST_RET: begin
        stb.pop      = 1'b1;
        stb.item     = idxItem(popIdx);
        stb.holdHigh = (idxItem(popIdx) == ITEM_HIGH);
        stb.ldRet    = (cnt == frameLen - CNT_W'(1));
        lastStep     = stb.ldRet;
      end
      default: ;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign pcLoad = stb.ldCall | stb.ldRet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      snapLegacy <= 1'b1;
      snapFast   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (callReq) begin
            state      <= ST_CALL;
            snapLegacy <= legacyMode;
            snapFast   <= callFast;
          end else if (retReq) begin
            state      <= ST_RET;
            snapLegacy <= legacyMode;
          end
        end
        default: begin
          if (lastStep) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/callstk_dp.sv
module callstk_dp
  import callstk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               callFast,
  input  logic [PC_W-1:0]    callTarget,
  input  logic [PC_W-1:0]    retAddr,
  input  logic [LOC_W-1:0]   memRdata,
  output logic               legacyMode,
  output logic               stackBank,
  output logic               wrErr,
  output logic [SP_W-1:0]    spOut,
  output logic [PC_W-1:0]    pcOut,
  output logic               memWe,
  output logic               memRe,
  output logic [MADDR_W-1:0] memAddr,
  output logic [LOC_W-1:0]   memWdata
);
  logic [REG_W-1:0] modeReg;
  logic [REG_W-1:0] snapReg;
  logic [PC_W-1:0]  tgtHold;
  logic [PC_W-1:0]  retHold;
  logic [HI_W-1:0]  highHold;
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  spDec;
  logic             regHit;
  logic             regBad;

  assign regHit = regWrEn && (regAddr == SBS_ADDR);
  assign regBad = regWrData[2] | regWrData[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg <= 4'b1000;
      wrErr   <= 1'b0;
    end else begin
      wrErr <= regHit && regBad;
      if (regHit && !regBad) modeReg <= regWrData;
    end
  end

  assign legacyMode = modeReg[3];
  assign stackBank  = modeReg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snapReg <= 4'b1000;
      tgtHold <= '0;
      retHold <= '0;
    end else if (stb.snap) begin
      snapReg <= modeReg;
      retHold <= retAddr;
      tgtHold <= callFast ? {{(PC_W-FAST_W){1'b0}}, callTarget[FAST_W-1:0]}
                          : callTarget;
    end
  end

  assign spDec = sp - SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= '0;
      highHold <= '0;
    end else begin
      if (stb.push)     sp <= spDec;
      else if (stb.pop) sp <= sp + SP_W'(1);
      if (stb.pop && stb.holdHigh) highHold <= memRdata[HI_W-1:0];
    end
  end

  always_comb begin
    case (stb.item)
      ITEM_LOW:  memWdata = retHold[LOC_W-1:0];
      ITEM_HIGH: memWdata = {{(LOC_W-HI_W){1'b0}}, retHold[PC_W-1:LOC_W]};
      default:   memWdata = {{(LOC_W-REG_W){1'b0}}, snapReg};
    endcase
  end

  assign memWe   = stb.push;
  assign memRe   = stb.pop;
  assign memAddr = {snapReg[0], (stb.push ? spDec : sp)};
  assign spOut   = sp;

  always_comb begin
    if (stb.ldCall)     pcOut = tgtHold;
    else if (stb.ldRet) pcOut = {highHold, memRdata};
    else                pcOut = '0;
  end
endmodule

// File: rtl/callstack_ctl.sv
module callstack_ctl
  import callstk_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               callReq,
  input  logic               callFast,
  input  logic [PC_W-1:0]    callTarget,
  input  logic [PC_W-1:0]    retAddr,
  input  logic               retReq,
  output logic               busy,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic               wrErr,
  output logic               legacyMode,
  output logic               stackBank,
  output logic [SP_W-1:0]    spOut,
  output logic               memWe,
  output logic               memRe,
  output logic [MADDR_W-1:0] memAddr,
  output logic [LOC_W-1:0]   memWdata,
  input  logic [LOC_W-1:0]   memRdata
);
  strobe_t stb;

  callstk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .callReq    (callReq),
    .callFast   (callFast),
    .retReq     (retReq),
    .legacyMode (legacyMode),
    .stb        (stb),
    .busy       (busy),
    .pcLoad     (pcLoad)
  );

  callstk_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .regWrEn    (regWrEn),
    .regAddr    (ADDR_W'(regAddr)),
    .regWrData  (regWrData),
    .callFast   (callFast),
    .callTarget (callTarget),
    .retAddr    (retAddr),
    .memRdata   (memRdata),
    .legacyMode (legacyMode),
    .stackBank  (stackBank),
    .wrErr      (wrErr),
    .spOut      (spOut),
    .pcOut      (pcOut),
    .memWe      (memWe),
    .memRe      (memRe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );
endmodule

// File: rtl/callstk_chk.sv
module callstk_chk
  import callstk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic              wrErr,
  input logic              legacyMode,
  input logic              stackBank,
  input logic              busy,
  input logic              pcLoad,
  input logic [SP_W-1:0]   spOut,
  input logic              memWe,
  input logic              memRe
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (legacyMode && !stackBank && !busy && spOut == '0));

  a_r3_bad_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == SBS_ADDR && (regWrData[2] || regWrData[1]))
      |=> (wrErr && $stable({legacyMode, stackBank})));

  a_r6_push_predecrement: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |=> (spOut == $past(spOut) - SP_W'(1)));

  a_r7_pop_postincrement: assert property (@(posedge clk) disable iff (!rst_n)
    memRe |=> (spOut == $past(spOut) + SP_W'(1)));

  a_r6_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWe && memRe));

  a_r4_load_ends_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    pcLoad |=> !busy);

  a_r9_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memWe && !memRe && !pcLoad));
endmodule

bind callstack_ctl callstk_chk chk (.*);

// File: tb/callstack_ctl_test.sv
`timescale 1ns/1ps
module callstack_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [3:0]  regWrData = '0;
  logic        callReq = 1'b0;
  logic        callFast = 1'b0;
  logic [13:0] callTarget = '0;
  logic [13:0] retAddr = '0;
  logic        retReq = 1'b0;
  logic        busy, pcLoad, wrErr, legacyMode, stackBank, memWe, memRe;
  logic [13:0] pcOut;
  logic [7:0]  spOut, memWdata, memRdata;
  logic [8:0]  memAddr;

  logic [7:0]  ram [0:511];
  logic [16:0] expWr[$];
  logic [13:0] expPc[$];
  logic [13:0] retStack[$];
  logic        mMode = 1'b1;
  logic        mBank = 1'b0;
  logic [7:0]  mSp = '0;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  callstack_ctl uut (.*);

  always @(posedge clk) if (memWe) ram[memAddr] <= memWdata;
  assign memRdata = ram[memAddr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (memWe) begin
        if (expWr.size() == 0) chk(0, "R9", "unexpected stack write", {memAddr, memWdata}, 0);
        else begin
          logic [16:0] e;
          e = expWr.pop_front();
          chk({memAddr, memWdata} == e, "R6", "stack write addr/data", {memAddr, memWdata}, e);
        end
      end
      if (pcLoad) begin
        if (expPc.size() == 0) chk(0, "R9", "unexpected pc load", pcOut, 0);
        else begin
          logic [13:0] p;
          p = expPc.pop_front();
          chk(pcOut == p, "R4", "loaded pc", pcOut, p);
        end
      end
    end
  end

  task automatic regWrite(input logic [11:0] a, input logic [3:0] d);
    bit hit, bad;
    hit = (a == 12'hF84);
    bad = d[2] | d[1];
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (hit && !bad) begin mMode = d[3]; mBank = d[0]; end
    chk(wrErr == (hit && bad), "R3", "wrErr after write", wrErr, hit && bad);
    chk({legacyMode, stackBank} == {mMode, mBank}, "R2", "register after write",
        {legacyMode, stackBank}, {mMode, mBank});
    @(negedge clk);
    chk(wrErr == 1'b0, "R3", "wrErr one cycle only", wrErr, 0);
  endtask

  // call; optional same-cycle register write, simultaneous return and busy pokes
  task automatic doCall(input bit fast, input logic [13:0] tgt, input logic [13:0] ra,
                        input bit sameWr, input logic [3:0] wd,
                        input bit both, input bit poke, input string req);
    int frame, expLen, n;
    logic [7:0] s;
    frame  = mMode ? 2 : 3;
    expLen = frame + (fast ? 0 : 1);
    s = mSp;
    s = s - 8'd1; expWr.push_back({mBank, s, ra[7:0]});
    s = s - 8'd1; expWr.push_back({mBank, s, 2'b00, ra[13:8]});
    if (!mMode) begin
      s = s - 8'd1; expWr.push_back({mBank, s, 4'h0, mMode, 2'b00, mBank});
    end
    expPc.push_back(fast ? {3'b000, tgt[10:0]} : tgt);
    retStack.push_back(ra);
    mSp = s;
    @(negedge clk);
    callReq = 1'b1; callFast = fast; callTarget = tgt; retAddr = ra; retReq = both;
    if (sameWr) begin regWrEn = 1'b1; regAddr = 12'hF84; regWrData = wd; end
    @(negedge clk);
    callReq = 1'b0; retReq = 1'b0; regWrEn = 1'b0;
    if (sameWr) begin mMode = wd[3]; mBank = wd[0]; end
    n = 0;
    while (busy && n < 20) begin
      if (n == 0 && poke) begin callReq = 1'b1; retReq = 1'b1; end
      if (n == 1) begin callReq = 1'b0; retReq = 1'b0; end
      n++;
      @(negedge clk);
    end
    callReq = 1'b0; retReq = 1'b0;
    chk(n == expLen, req, "call busy cycles", n, expLen);
    chk(spOut == mSp, "R10", "sp after call", spOut, mSp);
  endtask

  task automatic doRet(input string req);
    int frame, n;
    logic [13:0] p;
    frame = mMode ? 2 : 3;
    p = retStack.pop_back();
    expPc.push_back(p);
    mSp = mSp + 8'(frame);
    @(negedge clk);
    retReq = 1'b1;
    @(negedge clk);
    retReq = 1'b0;
    n = 0;
    while (busy && n < 20) begin n++; @(negedge clk); end
    chk(n == frame, req, "return busy cycles", n, frame);
    chk(spOut == mSp, "R7", "sp after return", spOut, mSp);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(legacyMode == 1'b1, "R1", "reset mode", legacyMode, 1);
    chk(stackBank == 1'b0, "R1", "reset bank", stackBank, 0);
    chk(spOut == 8'h00, "R1", "reset sp", spOut, 0);
    chk(!busy && !pcLoad && !wrErr, "R1", "reset strobes", {busy, pcLoad, wrErr}, 0);

    regWrite(12'hF85, 4'b0001);   // R2 wrong address ignored
    regWrite(12'hF84, 4'b0010);   // R3 prohibited bank code
    regWrite(12'hF84, 4'b1100);   // R3 bit 2 set

    // legacy mode: R4 full call wraps SP (R10), R5 fast call, R7 returns
    doCall(0, 14'h2ABC, 14'h1234, 0, 4'h0, 0, 0, "R4");
    chk(spOut == 8'hFE, "R10", "sp wrapped below zero", spOut, 8'hFE);
    doCall(1, 14'h3FFF, 14'h0BCD, 0, 4'h0, 0, 0, "R5");
    doRet("R7");
    doRet("R7");
    chk(spOut == 8'h00, "R10", "sp wrapped back to zero", spOut, 0);

    // extended mode, bank 1
    regWrite(12'hF84, 4'b0001);
    doCall(0, 14'h1555, 14'h3A5C, 0, 4'h0, 0, 0, "R4");
    doCall(1, 14'h2F0F, 14'h0077, 0, 4'h0, 0, 0, "R5");
    doRet("R7");
    doRet("R7");

    // R8: write to legacy/bank0 in the accepting cycle; frame stays extended in bank 1
    begin
      logic [7:0] s0;
      s0 = mSp;
      expWr.push_back({1'b1, s0 - 8'd1, 8'h21});
      expWr.push_back({1'b1, s0 - 8'd2, 8'h03});
      expWr.push_back({1'b1, s0 - 8'd3, 8'h01});
      expPc.push_back(14'h0444);
      retStack.push_back(14'h0321);
      mSp = s0 - 8'd3;
      @(negedge clk);
      callReq = 1'b1; callFast = 1'b0; callTarget = 14'h0444; retAddr = 14'h0321;
      regWrEn = 1'b1; regAddr = 12'hF84; regWrData = 4'b1000;
      @(negedge clk);
      callReq = 1'b0; regWrEn = 1'b0;
      chk(legacyMode == 1'b1, "R8", "new mode visible next cycle", legacyMode, 1);
      begin
        int n = 0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        chk(n == 4, "R8", "latency from old extended mode", n, 4);
      end
      mMode = 1'b1; mBank = 1'b0;
      chk(spOut == mSp, "R8", "sp after snapshot call", spOut, mSp);
    end
    regWrite(12'hF84, 4'b0001);
    doRet("R7");

    // R9: call and return together, pokes while busy
    regWrite(12'hF84, 4'b1000);
    doCall(0, 14'h0ACE, 14'h1F1F, 0, 4'h0, 1, 1, "R9");
    doRet("R9");
    repeat (4) @(negedge clk);
    chk(expWr.size() == 0, "R6", "all frame writes seen", expWr.size(), 0);
    chk(expPc.size() == 0, "R9", "all pc loads seen", expPc.size(), 0);
    chk(spOut == 8'h00, "R7", "stack balanced", spOut, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule